// File: doc/BRIEF.md
# Command Block Launch and Status Tracker

The tracker holds one command block that software reaches through 32-bit word writes and reads. Word 0 is the low control word and carries the opcode, the extended opcode, the transfer type, two access attributes, a 3-bit mode field and a start bit. Word 1 is the upper control word, and hardware owns its status and substatus fields. The operand doubleword `k` is made of word `2+2k` (low half) and word `3+2k` (high half). The operands sit in two inferable 32-bit RAM banks, and the execution engine reads them through its own read port.

Writing word 0 with the start bit set launches the command. The status moves from idle to active and the decoded fields go out on the execution port with a one-cycle valid. If the opcode is not one the block knows, the command ends at once in the exception state.

When the engine reports completion, the block records the following:
- a final status
- the 4-bit substatus
- the 18-bit exception cause vector
- a retryable flag

It can also pulse an interrupt. An acknowledge input returns a finished block to idle.

Top module: `cmd_block_tracker`

## Requirements
- R1: After reset the status is idle (0). Substatus, cause, retryable, interrupt, overrun and execution valid are all 0.
- R2: A write to word 0 with bit 0 set, while the status is not active (2) and with an opcode (bits 23:16) of 0x0F or below, makes the status active on the next cycle. It also gives one execution-valid pulse carrying these fields: extended opcode bits 31:24, opcode 23:16, attribute 1 bits 14:13, attribute 0 bits 12:11, transfer type 10:8 and mode 3:1.
- R3: A write to word 0 with bit 0 clear stores the word, which reads back unchanged, and launches nothing.
- R4: A start write with an opcode above 0x0F sets the status to exception (1) and the cause to exactly bit 1. No execution-valid pulse is issued.
- R5: On completion while active, the final status is set by the cause. A non-zero cause gives exception (1). A zero cause with the OS-request input set gives OS request (3). Otherwise the status is idle (0).
- R6: The retryable flag is 1 only when the recorded cause is non-zero and has no set bit outside bits 8, 9, 10 and 16.
- R7: The completion substatus is recorded unchanged. Its low 3 bits are the message-queue result and its bit 3 flags an implicit abort.
- R8: When mode bit 2 (word 0 bit 3) of the launched command is set, the interrupt output pulses for one cycle with the completion. A rejected command raises no interrupt.
- R9: A start write while the status is active is ignored, and word 0 keeps its old value. It sets a sticky overrun flag.
- R10: A read of word 1 returns the status in bits 25:24 and the substatus in bits 29:26, with the other bits as last written. A read issued in the cycle of a status update already returns the new values.
- R11: The acknowledge input, while the status is not active, clears status, substatus, cause, retryable and overrun. While the status is active it has no effect.
- R12: Operand words read back through both the word port and the execution read port, one cycle after the request. A completion that arrives while the status is not active is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr | input | 1 | Word write strobe |
| cpu_waddr | input | AW | Word write index |
| cpu_wdata | input | 32 | Word write data |
| cpu_rd | input | 1 | Word read strobe |
| cpu_raddr | input | AW | Word read index |
| cpu_rdata | output | 32 | Read data, one cycle after the strobe |
| ack_idle | input | 1 | Return a finished block to idle |
| exe_valid | output | 1 | One-cycle launch pulse |
| exe_opcode | output | 8 | Opcode |
| exe_exopc | output | 8 | Extended opcode |
| exe_xtype | output | 3 | Transfer type |
| exe_attr0 | output | 2 | Access attribute 0 |
| exe_attr1 | output | 2 | Access attribute 1 |
| exe_mode | output | 3 | Mode field |
| exe_rd_en | input | 1 | Operand read request from the engine |
| exe_rd_idx | input | IW | Operand doubleword index |
| exe_rd_data | output | 64 | Operand doubleword, one cycle later |
| done_valid | input | 1 | Completion strobe |
| done_os | input | 1 | Completion asks for OS assistance |
| done_substatus | input | 4 | Completion substatus |
| done_cause | input | 18 | Completion exception cause vector |
| status_o | output | 2 | Current status |
| substatus_o | output | 4 | Current substatus |
| cause_o | output | 18 | Recorded cause vector |
| retryable_o | output | 1 | Recorded exception is retryable |
| irq_o | output | 1 | Completion interrupt pulse |
| overrun_o | output | 1 | Sticky start-while-active flag |

## Verification
The assertions watch the following on every cycle:
- an execution pulse appears only together with the active status and a legal opcode;
- the active status is held until a completion arrives;
- the interrupt is a single-cycle pulse that follows an active status;
- the retryable flag appears only with the exception status;
- overrun persists until acknowledged.

The exact field positions of a launch, the retry mask classification, the same-cycle status read and the choice of final status need concrete words and cause vectors. So does the ignoring of a stray start, an acknowledge or a completion. The bench's scenarios cover these, with a scoreboard that matches every launch and interrupt to an expected entry.

// File: rtl/cbt_pkg.sv
package cbt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_EXC    = 2'd1,
    ST_ACTIVE = 2'd2,
    ST_OSREQ  = 2'd3
  } cb_state_e;

  localparam int CAUSE_W     = 18;
  localparam int OPC_LAST    = 15;
  localparam int CAUSE_BADOP = 1;

  // cause bits 8, 9, 10 and 16 may be retried
  localparam logic [CAUSE_W-1:0] RETRY_MASK = 18'h10700;

  // layout of the low control word (the engine decodes these positions)
  typedef struct packed {
    logic [7:0] exopc;
    logic [7:0] opc;
    logic       rsv_hi;
    logic [1:0] attr1;
    logic [1:0] attr0;
    logic [2:0] xtype;
    logic [3:0] rsv_lo;
    logic [2:0] mode;
    logic       start;
  } ctl_word_t;

  function automatic logic can_retry(input logic [CAUSE_W-1:0] c);
    return (c != '0) && ((c & ~RETRY_MASK) == '0);
  endfunction

endpackage

// File: rtl/cbt_opnd_ram.sv
module cbt_opnd_ram #(
  parameter int NUM = 4,
  parameter int IW  = 2
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic          wr_half,
  input  logic [IW-1:0] wr_idx,
  input  logic [31:0]   wr_data,
  input  logic          a_rd,
  input  logic [IW-1:0] a_idx,
  output logic [63:0]   a_data,
  input  logic          b_rd,
  input  logic [IW-1:0] b_idx,
  output logic [63:0]   b_data
);

  for (genvar h = 0; h < 2; h++) begin : g_bank
    logic [31:0] mem [NUM];
    logic [31:0] a_q;
    logic [31:0] b_q;

    always_ff @(posedge clk) begin
      if (wr_en && (wr_half == 1'(h))) mem[wr_idx] <= wr_data;
      if (a_rd) a_q <= mem[a_idx];
      if (b_rd) b_q <= mem[b_idx];
    end
  end

  assign a_data = {g_bank[1].a_q, g_bank[0].a_q};
  assign b_data = {g_bank[1].b_q, g_bank[0].b_q};

endmodule

// File: rtl/cbt_seq.sv
module cbt_seq
  import cbt_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               start_wr,
  input  logic [7:0]         new_opc,
  input  logic               ack,
  input  logic               irq_en,
  input  logic               done_valid,
  input  logic               done_os,
  input  logic [3:0]         done_sub,
  input  logic [CAUSE_W-1:0] done_cause,
  output logic [1:0]         st_q,
  output logic [1:0]         st_d,
  output logic [3:0]         sub_q,
  output logic [3:0]         sub_d,
  output logic [CAUSE_W-1:0] cause_q,
  output logic               retry_q,
  output logic               irq_q,
  output logic               exe_q,
  output logic               ovr_q
);

  logic [CAUSE_W-1:0] cause_d;
  logic retry_d, irq_d, exe_d, ovr_d;
  logic busy;

  assign busy = (st_q == ST_ACTIVE);

  always_comb begin
    st_d    = st_q;
    sub_d   = sub_q;
    cause_d = cause_q;
    retry_d = retry_q;
    ovr_d   = ovr_q;
    irq_d   = 1'b0;
    exe_d   = 1'b0;
    if (busy) begin
      if (start_wr) ovr_d = 1'b1;
      if (done_valid) begin
        cause_d = done_cause;
        sub_d   = done_sub;
        retry_d = can_retry(done_cause);
        irq_d   = irq_en;
        if (done_cause != '0) st_d = ST_EXC;
        else if (done_os)     st_d = ST_OSREQ;
        else                  st_d = ST_IDLE;
      end
    end else begin
      if (ack) begin
        st_d    = ST_IDLE;
        sub_d   = '0;
        cause_d = '0;
        retry_d = 1'b0;
        ovr_d   = 1'b0;
      end
      if (start_wr) begin
        sub_d   = '0;
        retry_d = 1'b0;
        if (new_opc > 8'(OPC_LAST)) begin
          st_d    = ST_EXC;
          cause_d = CAUSE_W'(1) << CAUSE_BADOP;
        end else begin
          st_d    = ST_ACTIVE;
          cause_d = '0;
          exe_d   = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      sub_q   <= '0;
      cause_q <= '0;
      retry_q <= 1'b0;
      irq_q   <= 1'b0;
      exe_q   <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      sub_q   <= sub_d;
      cause_q <= cause_d;
      retry_q <= retry_d;
      irq_q   <= irq_d;
      exe_q   <= exe_d;
      ovr_q   <= ovr_d;
    end
  end

endmodule

// File: rtl/cmd_block_tracker.sv
module cmd_block_tracker
  import cbt_pkg::*;
#(
  parameter int  NUM_OPND = 4,
  localparam int WORDS    = 2 + 2 * NUM_OPND,
  localparam int AW       = $clog2(WORDS),
  localparam int IW       = (NUM_OPND > 1) ? $clog2(NUM_OPND) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cpu_wr,
  input  logic [AW-1:0]      cpu_waddr,
  input  logic [31:0]        cpu_wdata,
  input  logic               cpu_rd,
  input  logic [AW-1:0]      cpu_raddr,
  output logic [31:0]        cpu_rdata,
  input  logic               ack_idle,
  output logic               exe_valid,
  output logic [7:0]         exe_opcode,
  output logic [7:0]         exe_exopc,
  output logic [2:0]         exe_xtype,
  output logic [1:0]         exe_attr0,
  output logic [1:0]         exe_attr1,
  output logic [2:0]         exe_mode,
  input  logic               exe_rd_en,
  input  logic [IW-1:0]      exe_rd_idx,
  output logic [63:0]        exe_rd_data,
  input  logic               done_valid,
  input  logic               done_os,
  input  logic [3:0]         done_substatus,
  input  logic [CAUSE_W-1:0] done_cause,
  output logic [1:0]         status_o,
  output logic [3:0]         substatus_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic               retryable_o,
  output logic               irq_o,
  output logic               overrun_o
);

  localparam logic [AW-1:0] A_LO  = AW'(0);
  localparam logic [AW-1:0] A_HI  = AW'(1);
  localparam logic [AW-1:0] A_OP0 = AW'(2);

  ctl_word_t   ctl_lo_q;
  logic [1:0]  hi_top_q;
  logic [23:0] hi_low_q;
  logic [1:0]  st_q, st_d;
  logic [3:0]  sub_q, sub_d;
  logic        wr_lo, start_wr, busy;

  assign busy     = (st_q == ST_ACTIVE);
  assign wr_lo    = cpu_wr && (cpu_waddr == A_LO);
  assign start_wr = wr_lo && cpu_wdata[0];

  // control words: low word frozen while a command runs
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_lo_q <= '0;
      hi_top_q <= '0;
      hi_low_q <= '0;
    end else begin
      if (wr_lo && !busy) ctl_lo_q <= ctl_word_t'(cpu_wdata);
      if (cpu_wr && (cpu_waddr == A_HI)) begin
        hi_top_q <= cpu_wdata[31:30];
        hi_low_q <= cpu_wdata[23:0];
      end
    end
  end

  cbt_seq u_seq (
    .clk        (clk),
    .rst        (rst),
    .start_wr   (start_wr),
    .new_opc    (cpu_wdata[23:16]),
    .ack        (ack_idle),
    .irq_en     (ctl_lo_q.mode[2]),
    .done_valid (done_valid),
    .done_os    (done_os),
    .done_sub   (done_substatus),
    .done_cause (done_cause),
    .st_q       (st_q),
    .st_d       (st_d),
    .sub_q      (sub_q),
    .sub_d      (sub_d),
    .cause_q    (cause_o),
    .retry_q    (retryable_o),
    .irq_q      (irq_o),
    .exe_q      (exe_valid),
    .ovr_q      (overrun_o)
  );

  // operand address decode
  logic [AW-1:0] w_off, r_off;
  logic          w_opnd, r_opnd;
  logic [IW-1:0] w_idx, r_idx;

  assign w_off  = cpu_waddr - A_OP0;
  assign r_off  = cpu_raddr - A_OP0;
  assign w_opnd = cpu_wr && (cpu_waddr >= A_OP0) && ({1'b0, cpu_waddr} < (AW+1)'(WORDS));
  assign r_opnd = cpu_rd && (cpu_raddr >= A_OP0) && ({1'b0, cpu_raddr} < (AW+1)'(WORDS));
  assign w_idx  = IW'(w_off >> 1);
  assign r_idx  = IW'(r_off >> 1);

  logic [63:0] cpu_opnd_q;

  cbt_opnd_ram #(.NUM(NUM_OPND), .IW(IW)) u_ram (
    .clk     (clk),
    .wr_en   (w_opnd),
    .wr_half (w_off[0]),
    .wr_idx  (w_idx),
    .wr_data (cpu_wdata),
    .a_rd    (exe_rd_en),
    .a_idx   (exe_rd_idx),
    .a_data  (exe_rd_data),
    .b_rd    (r_opnd),
    .b_idx   (r_idx),
    .b_data  (cpu_opnd_q)
  );

  // read path: the status word samples next-state values
  logic [1:0]  rd_sel_q;
  logic [31:0] rd_ctl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_sel_q <= '0;
      rd_ctl_q <= '0;
    end else if (cpu_rd) begin
      rd_sel_q <= {r_opnd, r_off[0]};
      if (cpu_raddr == A_LO)      rd_ctl_q <= ctl_lo_q;
      else if (cpu_raddr == A_HI) rd_ctl_q <= {hi_top_q, sub_d, st_d, hi_low_q};
      else                        rd_ctl_q <= '0;
    end
  end

  assign cpu_rdata = rd_sel_q[1] ? (rd_sel_q[0] ? cpu_opnd_q[63:32] : cpu_opnd_q[31:0])
                                 : rd_ctl_q;

  assign exe_opcode  = ctl_lo_q.opc;
  assign exe_exopc   = ctl_lo_q.exopc;
  assign exe_xtype   = ctl_lo_q.xtype;
  assign exe_attr0   = ctl_lo_q.attr0;
  assign exe_attr1   = ctl_lo_q.attr1;
  assign exe_mode    = ctl_lo_q.mode;
  assign status_o    = st_q;
  assign substatus_o = sub_q;

endmodule

// File: rtl/cbt_checker.sv
module cbt_checker
  import cbt_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       exe_valid,
  input logic [7:0] exe_opcode,
  input logic [1:0] status_o,
  input logic       retryable_o,
  input logic       irq_o,
  input logic       overrun_o,
  input logic       ack_idle,
  input logic       done_valid
);

  AST_LAUNCH_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    exe_valid |-> status_o == ST_ACTIVE); // R2

  AST_LAUNCH_LEGAL_OPC: assert property (@(posedge clk) disable iff (rst)
    exe_valid |-> exe_opcode <= 8'(OPC_LAST)); // R4

  AST_ACTIVE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (status_o == ST_ACTIVE && !done_valid) |=> status_o == ST_ACTIVE); // R5

  AST_RETRY_ONLY_EXC: assert property (@(posedge clk) disable iff (rst)
    retryable_o |-> status_o == ST_EXC); // R6

  AST_IRQ_AFTER_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> ($past(status_o) == ST_ACTIVE && status_o != ST_ACTIVE)); // R8

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
    irq_o |=> !irq_o); // R8

  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
    (overrun_o && !ack_idle) |=> overrun_o); // R9

endmodule

bind cmd_block_tracker cbt_checker i_cbt_checker (
  .clk         (clk),
  .rst         (rst),
  .exe_valid   (exe_valid),
  .exe_opcode  (exe_opcode),
  .status_o    (status_o),
  .retryable_o (retryable_o),
  .irq_o       (irq_o),
  .overrun_o   (overrun_o),
  .ack_idle    (ack_idle),
  .done_valid  (done_valid)
);

// File: tb/test_cmd_block_tracker.sv
module test_cmd_block_tracker;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] FIELD_MASK = 32'hFF_FF_7F_0E;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_wr = 1'b0, cpu_rd = 1'b0;
  logic [3:0]  cpu_waddr = '0, cpu_raddr = '0;
  logic [31:0] cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic        ack_idle = 1'b0;
  logic        exe_valid;
  logic [7:0]  exe_opcode, exe_exopc;
  logic [2:0]  exe_xtype, exe_mode;
  logic [1:0]  exe_attr0, exe_attr1;
  logic        exe_rd_en = 1'b0;
  logic [1:0]  exe_rd_idx = '0;
  logic [63:0] exe_rd_data;
  logic        done_valid = 1'b0, done_os = 1'b0;
  logic [3:0]  done_substatus = '0;
  logic [17:0] done_cause = '0;
  logic [1:0]  status_o;
  logic [3:0]  substatus_o;
  logic [17:0] cause_o;
  logic        retryable_o, irq_o, overrun_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [31:0] exp_launch[$];
  bit          exp_irq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_block_tracker i_cmd_block_tracker (.*);

  function automatic logic [31:0] mk(input logic [7:0] xo, input logic [7:0] op,
                                     input logic [1:0] a1, input logic [1:0] a0,
                                     input logic [2:0] xt, input logic [2:0] md,
                                     input logic st);
    return {xo, op, 1'b0, a1, a0, xt, 4'b0, md, st};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    cpu_wr = 1'b1; cpu_waddr = a; cpu_wdata = d;
    step();
    cpu_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    cpu_rd = 1'b1; cpu_raddr = a;
    step();
    cpu_rd = 1'b0;
    d = cpu_rdata;
  endtask

  task automatic launch(input logic [31:0] w);
    exp_launch.push_back(w);
    wr(4'd0, w);
  endtask

  task automatic complete(input logic os, input logic [3:0] sub, input logic [17:0] c,
                          input bit want_irq);
    if (want_irq) exp_irq.push_back(1'b1);
    done_valid = 1'b1; done_os = os; done_substatus = sub; done_cause = c;
    step();
    done_valid = 1'b0; done_os = 1'b0; done_substatus = '0; done_cause = '0;
  endtask

  task automatic ack();
    ack_idle = 1'b1;
    step();
    ack_idle = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (exe_valid) begin
        logic [31:0] got;
        got = {exe_exopc, exe_opcode, 1'b0, exe_attr1, exe_attr0, exe_xtype, 4'b0, exe_mode, 1'b0};
        checks++;
        if (exp_launch.size() == 0) begin
          errors++;
          $display("FAIL R2/R4 launch: actual %h expected none", got);
        end else begin
          logic [31:0] e;
          e = exp_launch.pop_front() & FIELD_MASK;
          if (got !== e) begin
            errors++;
            $display("FAIL R2 launch fields: actual %h expected %h", got, e);
          end
        end
      end
      if (irq_o) begin
        checks++;
        if (exp_irq.size() == 0) begin
          errors++;
          $display("FAIL R8 interrupt: actual 1 expected 0");
        end else begin
          void'(exp_irq.pop_front());
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [31:0] w0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1 reset state
    check("R1 status", status_o, 0);
    check("R1 substatus", substatus_o, 0);
    check("R1 cause", cause_o, 0);
    check("R1 flags", {retryable_o, irq_o, overrun_o, exe_valid}, 0);

    // R12 operands through both ports
    wr(4'd2, 32'h1111_0000);
    wr(4'd3, 32'h2222_0001);
    wr(4'd9, 32'hABCD_0003);
    rd(4'd3, r);  check("R12 word read hi", r, 32'h2222_0001);
    rd(4'd9, r);  check("R12 word read op3", r, 32'hABCD_0003);
    exe_rd_en = 1'b1; exe_rd_idx = 2'd0;
    step();
    exe_rd_en = 1'b0;
    check("R12 exe read", exe_rd_data, 64'h2222_0001_1111_0000);

    // R10 status word layout while idle
    wr(4'd1, 32'hFFFF_FFFF);
    rd(4'd1, r);  check("R10 status word idle", r, 32'hC0FF_FFFF);

    // R3 stored without start
    w0 = mk(8'h04, 8'h05, 2'd1, 2'd2, 3'd3, 3'b100, 1'b0);
    wr(4'd0, w0);
    check("R3 status stays idle", status_o, 0);
    rd(4'd0, r);  check("R3 word0 readback", r, w0);

    // R2 launch with interrupt mode
    w0 = mk(8'h04, 8'h0D, 2'd2, 2'd1, 3'd3, 3'b100, 1'b1);
    launch(w0);
    check("R2 status active", status_o, 2);

    // R9 start while active ignored
    wr(4'd0, mk(8'h00, 8'h01, 2'd0, 2'd0, 3'd0, 3'b000, 1'b1));
    check("R9 overrun set", overrun_o, 1);
    check("R9 still active", status_o, 2);
    rd(4'd0, r);  check("R9 word0 unchanged", r, w0);

    // R11 ack ignored while active
    ack();
    check("R11 ack ignored status", status_o, 2);
    check("R11 ack ignored overrun", overrun_o, 1);

    // R5 R6 R7 R8 R10 completion with same-cycle status read
    exp_irq.push_back(1'b1);
    done_valid = 1'b1; done_substatus = 4'hA; done_cause = 18'h00300;
    cpu_rd = 1'b1; cpu_raddr = 4'd1;
    step();
    done_valid = 1'b0; done_substatus = '0; done_cause = '0; cpu_rd = 1'b0;
    check("R10 same-cycle read", cpu_rdata, 32'hC0FF_FFFF & ~32'h3F00_0000 | (32'hA << 26) | (32'h1 << 24));
    check("R5 exception status", status_o, 1);
    check("R7 substatus", substatus_o, 4'hA);
    check("R6 retryable bits 8,9", retryable_o, 1);
    check("R5 cause recorded", cause_o, 18'h00300);

    // R11 ack from finished state
    ack();
    check("R11 ack status", status_o, 0);
    check("R11 ack cause/flags", {cause_o, retryable_o, overrun_o, substatus_o}, 0);

    // R12 completion while idle ignored
    complete(1'b1, 4'h5, 18'h3FFFF, 1'b0);
    check("R12 stray completion status", status_o, 0);
    check("R12 stray completion cause", cause_o, 0);

    // R4 illegal opcode, no launch, no interrupt
    wr(4'd0, mk(8'h00, 8'h10, 2'd0, 2'd0, 3'd0, 3'b100, 1'b1));
    check("R4 exception status", status_o, 1);
    check("R4 cause bit1 only", cause_o, 18'h2);
    check("R4 not retryable", retryable_o, 0);
    step();
    check("R8 no interrupt on reject", irq_o, 0);

    // R5 OS request, no interrupt (mode bit 2 clear)
    ack();
    launch(mk(8'h0A, 8'h0F, 2'd0, 2'd3, 3'd6, 3'b001, 1'b1));
    complete(1'b1, 4'h3, 18'h0, 1'b0);
    check("R5 OS request status", status_o, 3);
    check("R7 substatus page overflow", substatus_o, 4'h3);
    check("R6 no cause not retryable", retryable_o, 0);

    // R6 bit outside mask
    ack();
    launch(mk(8'h00, 8'h09, 2'd0, 2'd0, 3'd3, 3'b100, 1'b1));
    complete(1'b0, 4'h0, 18'h00101, 1'b1);
    check("R6 bit0 blocks retry", retryable_o, 0);

    // R6 bit16 alone
    ack();
    launch(mk(8'h01, 8'h0A, 2'd0, 2'd0, 3'd2, 3'b000, 1'b1));
    complete(1'b0, 4'h8, 18'h10000, 1'b0);
    check("R6 bit16 retryable", retryable_o, 1);

    // R5 clean completion
    ack();
    launch(mk(8'h00, 8'h00, 2'd0, 2'd0, 3'd0, 3'b000, 1'b1));
    complete(1'b0, 4'h0, 18'h0, 1'b0);
    check("R5 idle on clean finish", status_o, 0);

    repeat (3) step();
    check("R2 launch queue drained", exp_launch.size(), 0);
    check("R8 irq queue drained", exp_irq.size(), 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule